// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block watches a running calendar and raises a one-cycle alarm pulse when the current time agrees with a stored alarm time. Only the fields picked by a 4-bit mask code take part in the comparison. The calendar comes in as BCD bytes from a separate time counter: seconds, minutes, hours, weekday, day of month and month. That counter also supplies a half-second tick and a one-second tick. The comparison is made only in a cycle that carries a tick, so one calendar match gives exactly one pulse.

Software reaches the block through a small byte-wide register bus with four locations:
- a configuration byte, which holds the enable, the chime flag, the mask code and a 2-bit window pointer;
- an 8-bit repeat counter;
- a high-byte window onto the six stored alarm fields;
- a low-byte window onto the same six fields.

Each access to the high window moves the pointer one step down, so the alarm fields can be filled or read in a short burst. The repeat counter counts the remaining alarm events. With chime off, the alarm switches itself off once the count is exhausted. With chime on, the alarm keeps running and the counter wraps.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the configuration byte, the repeat counter, the window pointer, all six alarm fields and `alarm_pulse` are 0.
- R2: With the alarm enabled, mask code 0 gives a pulse for every `half_tick` and mask code 1 gives a pulse for every `sec_tick`. The pulse appears in the cycle after the tick and lasts exactly one cycle.
- R3: Mask codes 2 to 9 fire on `sec_tick` only when a set of fields matches. Each code adds to the set of the code before it, except where noted:
  - 2: the seconds ones digit (bits 3:0);
  - 3: the full seconds;
  - 4: the minutes ones digit;
  - 5: the full minutes;
  - 6: the hours;
  - 7: the weekday;
  - 8: the day, which takes the place of the weekday;
  - 9: the month.
- R4: Mask codes 10 to 15 never fire, and nothing fires while the enable bit is 0.
- R5: In yearly mode, an alarm set to month 0x02, day 0x29 fires only when the current date is 0x02/0x29, which is the leap-year date.
- R6: When an alarm event occurs while the repeat counter is 0 and chime is 0, the enable bit clears.
- R7: Each alarm event decrements the repeat counter. With chime on, it wraps from 0x00 to 0xFF. With chime off, it holds at 0x00.
- R8: Bus address 0 is the configuration byte: bit 7 enable, bit 6 chime, bits 5:2 mask, bits 1:0 pointer. Address 1 is the repeat counter, address 2 the high window and address 3 the low window.
  - The high window maps pointer 0, 1 and 2 to minutes, weekday and month.
  - The low window maps pointer 0, 1 and 2 to seconds, hours and day.
  - Each read or write of the high window decrements the pointer, which stops at 0. Low-window accesses leave the pointer unchanged.
- R9: At pointer 3, both windows read 0 and writes to them change no alarm field.
- R10: A bus write to the configuration byte or to the repeat counter in the same cycle as an alarm event takes priority over the auto-clear and the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Half-second strobe from the time counter |
| sec_tick | input | 1 | Whole-second strobe from the time counter |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_wday | input | 8 | Current weekday |
| cur_day | input | 8 | Current day of month, BCD |
| cur_month | input | 8 | Current month, BCD |
| bus_sel | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances the high-window pointer) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| alarm_pulse | output | 1 | One-cycle alarm interrupt |

## Verification
An alarm event and a software write to the configuration byte or to the repeat counter can land in the same clock edge. When that happens, the hardware auto-clear or decrement competes with the written value. The bench provokes this by raising a tick with matching fields while it writes those registers in the same cycle. It then reads the registers back and compares them with its reference model, in which the write always wins. High-window accesses in the same cycle as an event are also mixed in, to show that the pointer steps independently of the repeat logic.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 2;
  localparam int MASK_W = 4;
  localparam logic [MASK_W-1:0] MASK_HALF = 4'd0;
  localparam logic [MASK_W-1:0] MASK_LAST = 4'd9;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    byte_t sec;
    byte_t min;
    byte_t hour;
    byte_t wday;
    byte_t day;
    byte_t month;
  } rtc_time_t;

  typedef struct packed {
    logic              en;
    logic              chime;
    logic [MASK_W-1:0] mask;
    logic [PTR_W-1:0]  ptr;
  } alarm_cfg_t;

  typedef enum logic [1:0] {
    SEL_CFG = 2'd0,
    SEL_RPT = 2'd1,
    SEL_HI  = 2'd2,
    SEL_LO  = 2'd3
  } bus_sel_e;

  // pointer after a high-window access: steps down, floors at zero
  function automatic logic [PTR_W-1:0] ptr_after_access(input logic [PTR_W-1:0] p);
    return (p == '0) ? p : p - 1'b1;
  endfunction

  // which fields must agree for a given mask code (mask 0 handled by the caller)
  function automatic logic fields_match(input logic [MASK_W-1:0] mask,
                                        input rtc_time_t cur, input rtc_time_t alm);
    logic sec_lo, sec_f, min_lo, min_f, hr, wd, dy, mo;
    sec_lo = cur.sec[3:0] == alm.sec[3:0];
    sec_f  = cur.sec == alm.sec;
    min_lo = cur.min[3:0] == alm.min[3:0];
    min_f  = cur.min == alm.min;
    hr     = cur.hour == alm.hour;
    wd     = cur.wday == alm.wday;
    dy     = cur.day == alm.day;
    mo     = cur.month == alm.month;
    case (mask)
      4'd1:    return 1'b1;
      4'd2:    return sec_lo;
      4'd3:    return sec_f;
      4'd4:    return sec_f & min_lo;
      4'd5:    return sec_f & min_f;
      4'd6:    return sec_f & min_f & hr;
      4'd7:    return sec_f & min_f & hr & wd;
      4'd8:    return sec_f & min_f & hr & dy;
      4'd9:    return sec_f & min_f & hr & dy & mo;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MASK_W-1:0] mask,
  input  rtc_time_t         cur,
  input  rtc_time_t         alm,
  input  logic              half_tick,
  input  logic              sec_tick,
  output logic              alarm_evt,
  output logic              alarm_pulse
);
  logic half_hit;
  logic sec_hit;

  always_comb begin
    half_hit  = (mask == MASK_HALF) && half_tick;
    sec_hit   = sec_tick && fields_match(mask, cur, alm);
    alarm_evt = en && (half_hit || sec_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) alarm_pulse <= 1'b0;
    else        alarm_pulse <= alarm_evt;
  end

  // R4: reserved codes and disabled state stay silent
  assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> (en && mask <= MASK_LAST));

  // R2: a pulse is always the echo of a tick one cycle earlier
  assert_pulse_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(half_tick || sec_tick));
endmodule

// File: rtl/rtc_alarm_repeat.sv
module rtc_alarm_repeat #(
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             chime,
  input  logic             load,
  input  logic [RPT_W-1:0] load_val,
  output logic [RPT_W-1:0] rpt,
  output logic             expire
);
  logic step;

  always_comb begin
    expire = evt && (rpt == '0) && !chime;
    step   = evt && !expire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rpt <= '0;
    else if (load) rpt <= load_val;
    else if (step) rpt <= rpt - 1'b1;
  end

  // R7: each counted event lowers the count by one (wrapping under chime)
  assert_rpt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && (rpt != '0 || chime) && !load) |=> rpt == $past(rpt) - 1'b1);

  // R7: without chime the count floors at zero
  assert_rpt_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && rpt == '0 && !chime && !load) |=> rpt == '0);

  // R10: a load in the event cycle wins
  assert_rpt_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rpt == $past(load_val));
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  byte_t             bus_wdata,
  output byte_t             bus_rdata,
  input  byte_t             rpt,
  input  logic              expire,
  output logic              rpt_load,
  output alarm_cfg_t        cfg,
  output rtc_time_t         alm
);
  logic cfg_wr;
  logic hi_acc;
  logic hi_wr;
  logic lo_wr;

  always_comb begin
    cfg_wr   = bus_wr && (bus_sel == SEL_CFG);
    rpt_load = bus_wr && (bus_sel == SEL_RPT);
    hi_acc   = (bus_wr || bus_rd) && (bus_sel == SEL_HI);
    hi_wr    = bus_wr && (bus_sel == SEL_HI);
    lo_wr    = bus_wr && (bus_sel == SEL_LO);
  end

  // configuration byte: software write beats pointer step and auto-clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_wr) begin
      cfg <= alarm_cfg_t'(bus_wdata);
    end else begin
      if (hi_acc) cfg.ptr <= ptr_after_access(cfg.ptr);
      if (expire) cfg.en  <= 1'b0;
    end
  end

  // alarm fields behind the two windows
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm <= '0;
    end else begin
      if (hi_wr) begin
        case (cfg.ptr)
          2'd0:    alm.min   <= bus_wdata;
          2'd1:    alm.wday  <= bus_wdata;
          2'd2:    alm.month <= bus_wdata;
          default: ;
        endcase
      end
      if (lo_wr) begin
        case (cfg.ptr)
          2'd0:    alm.sec  <= bus_wdata;
          2'd1:    alm.hour <= bus_wdata;
          2'd2:    alm.day  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_sel)
      SEL_CFG: bus_rdata = byte_t'(cfg);
      SEL_RPT: bus_rdata = rpt;
      SEL_HI: begin
        case (cfg.ptr)
          2'd0:    bus_rdata = alm.min;
          2'd1:    bus_rdata = alm.wday;
          2'd2:    bus_rdata = alm.month;
          default: bus_rdata = '0;
        endcase
      end
      default: begin
        case (cfg.ptr)
          2'd0:    bus_rdata = alm.sec;
          2'd1:    bus_rdata = alm.hour;
          2'd2:    bus_rdata = alm.day;
          default: bus_rdata = '0;
        endcase
      end
    endcase
  end

  // R8: pointer floors at zero
  assert_ptr_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_acc && cfg.ptr == '0 && !cfg_wr) |=> cfg.ptr == '0);

  // R8: pointer steps down by one on a high-window access
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_acc && cfg.ptr != '0 && !cfg_wr) |=> cfg.ptr == $past(cfg.ptr) - 1'b1);

  // R8: the low window never moves the pointer
  assert_lo_ptr_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_sel == SEL_LO) |=> $stable(cfg.ptr));

  // R6: exhausted alarm disables itself
  assert_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cfg_wr) |=> !cfg.en);

  // R9: writes at the unimplemented slot leave every field untouched
  assert_hole_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_wr || lo_wr) && cfg.ptr == 2'd3) |=> $stable(alm));

  // R10: a configuration write wins over auto-clear
  assert_cfg_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg == alarm_cfg_t'($past(bus_wdata)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       sec_tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_wday,
  input  logic [7:0] cur_day,
  input  logic [7:0] cur_month,
  input  logic [1:0] bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       alarm_pulse
);
  localparam int RPT_W = DATA_W;

  rtc_time_t  cur_time;
  rtc_time_t  alm_time;
  alarm_cfg_t cfg;
  logic       alarm_evt;
  logic       rpt_expire;
  logic       rpt_load;
  byte_t      rpt_val;

  always_comb begin
    cur_time.sec   = cur_sec;
    cur_time.min   = cur_min;
    cur_time.hour  = cur_hour;
    cur_time.wday  = cur_wday;
    cur_time.day   = cur_day;
    cur_time.month = cur_month;
  end

  rtc_alarm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rpt       (rpt_val),
    .expire    (rpt_expire),
    .rpt_load  (rpt_load),
    .cfg       (cfg),
    .alm       (alm_time)
  );

  rtc_alarm_repeat #(.RPT_W(RPT_W)) u_repeat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (alarm_evt),
    .chime    (cfg.chime),
    .load     (rpt_load),
    .load_val (bus_wdata),
    .rpt      (rpt_val),
    .expire   (rpt_expire)
  );

  rtc_alarm_cmp u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (cfg.en),
    .mask        (cfg.mask),
    .cur         (cur_time),
    .alm         (alm_time),
    .half_tick   (half_tick),
    .sec_tick    (sec_tick),
    .alarm_evt   (alarm_evt),
    .alarm_pulse (alarm_pulse)
  );
endmodule

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_tick = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] cur [6];
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       alarm_pulse;

  int n_tests = 0;
  int n_fail = 0;
  string tag = "R1";

  // reference model state
  bit m_en, m_chime;
  int m_mask, m_ptr, m_rpt;
  int a_hi[3];  // minutes, weekday, month
  int a_lo[3];  // seconds, hours, day

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .sec_tick(sec_tick),
    .cur_sec(cur[0]), .cur_min(cur[1]), .cur_hour(cur[2]),
    .cur_wday(cur[3]), .cur_day(cur[4]), .cur_month(cur[5]),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_pulse(alarm_pulse)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_match();
    bit ok = 1'b1;
    if (m_mask >= 2) ok &= (cur[0][3:0] == a_lo[0][3:0]);
    if (m_mask >= 3) ok &= (cur[0] == a_lo[0]);
    if (m_mask >= 4) ok &= (cur[1][3:0] == a_hi[0][3:0]);
    if (m_mask >= 5) ok &= (cur[1] == a_hi[0]);
    if (m_mask >= 6) ok &= (cur[2] == a_lo[1]);
    if (m_mask == 7) ok &= (cur[3] == a_hi[1]);
    if (m_mask >= 8) ok &= (cur[4] == a_lo[2]);
    if (m_mask == 9) ok &= (cur[5] == a_hi[2]);
    return ok;
  endfunction

  function automatic int model_rd(input int sel);
    if (sel == 0) return (int'(m_en) << 7) | (int'(m_chime) << 6) | (m_mask << 2) | m_ptr;
    if (sel == 1) return m_rpt;
    if (m_ptr == 3) return 0;
    return (sel == 2) ? a_hi[m_ptr] : a_lo[m_ptr];
  endfunction

  // one clock: predict, advance, compare the pulse
  task automatic cyc();
    bit ev, wcfg, wrpt, hacc, ne, nc;
    int nm, np, nr;
    ev = m_en && ((m_mask == 0 && half_tick) ||
                  (m_mask >= 1 && m_mask <= 9 && sec_tick && model_match()));
    wcfg = bus_wr && bus_sel == 2'd0;
    wrpt = bus_wr && bus_sel == 2'd1;
    hacc = (bus_wr || bus_rd) && bus_sel == 2'd2;
    ne = m_en; nc = m_chime; nm = m_mask; np = m_ptr; nr = m_rpt;
    if (ev) begin
      if (m_rpt == 0 && !m_chime) ne = 1'b0;
      else nr = (m_rpt + 255) % 256;
    end
    if (wrpt) nr = bus_wdata;
    if (hacc && m_ptr > 0) np = m_ptr - 1;
    if (wcfg) begin
      ne = bus_wdata[7]; nc = bus_wdata[6]; nm = bus_wdata[5:2]; np = bus_wdata[1:0];
    end
    if (bus_wr && bus_sel == 2'd2 && m_ptr < 3) a_hi[m_ptr] = bus_wdata;
    if (bus_wr && bus_sel == 2'd3 && m_ptr < 3) a_lo[m_ptr] = bus_wdata;
    @(posedge clk);
    @(negedge clk);
    m_en = ne; m_chime = nc; m_mask = nm; m_ptr = np; m_rpt = nr;
    chk(alarm_pulse === ev, "alarm_pulse", alarm_pulse, ev);
    bus_wr = 1'b0; bus_rd = 1'b0; half_tick = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic wr(input int sel, input int data);
    bus_sel = sel[1:0]; bus_wdata = data[7:0]; bus_wr = 1'b1;
    cyc();
  endtask

  task automatic rd(input int sel);
    bus_sel = sel[1:0]; bus_rd = 1'b1;
    #1;
    chk(bus_rdata == model_rd(sel), $sformatf("read sel %0d", sel), bus_rdata, model_rd(sel));
    cyc();
  endtask

  task automatic peek(input int sel);  // read without strobe
    bus_sel = sel[1:0];
    #1;
    chk(bus_rdata == model_rd(sel), $sformatf("peek sel %0d", sel), bus_rdata, model_rd(sel));
  endtask

  task automatic tick(input bit whole);
    half_tick = 1'b1; sec_tick = whole;
    cyc();
  endtask

  task automatic set_match();
    cur[0] = 8'h45; cur[1] = 8'h30; cur[2] = 8'h13;
    cur[3] = 8'h03; cur[4] = 8'h29; cur[5] = 8'h02;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_en = 0; m_chime = 0; m_mask = 0; m_ptr = 0; m_rpt = 0;
    for (int i = 0; i < 3; i++) begin a_hi[i] = 0; a_lo[i] = 0; end
    for (int i = 0; i < 6; i++) cur[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    chk(alarm_pulse === 1'b0, "pulse after reset", alarm_pulse, 0);
    for (int s = 0; s < 4; s++) peek(s);

    tag = "R8";  // fill through the windows, pointer walks down
    wr(0, 8'h02);
    wr(3, 8'h29); wr(2, 8'h02);
    wr(3, 8'h13); wr(2, 8'h03);
    wr(3, 8'h45); wr(2, 8'h30);
    peek(0);
    wr(0, 8'h02);
    for (int k = 0; k < 4; k++) begin rd(3); rd(2); end
    peek(0);

    tag = "R9";
    wr(0, 8'h03);
    rd(3); wr(0, 8'h03); rd(2);
    wr(0, 8'h03); wr(3, 8'h77); wr(0, 8'h03); wr(2, 8'h66);
    for (int p = 0; p < 3; p++) begin
      wr(0, p); peek(2); peek(3);
    end

    tag = "R2";
    set_match();
    wr(0, 8'hC0);   // enable, chime, mask 0
    tick(0); tick(1); cyc(); tick(0);
    tag = "R7";
    peek(1);
    wr(0, 8'hC4);   // mask 1
    tag = "R2";
    tick(0); tick(1); tick(1); cyc();

    tag = "R3";
    for (int m = 2; m <= 9; m++) begin
      wr(0, 8'hC0 | (m << 2));
      set_match(); tick(1); tick(0);
      for (int f = 0; f < 6; f++) begin
        for (int b = 0; b < 2; b++) begin
          set_match();
          cur[f] = cur[f] ^ (b ? 8'h10 : 8'h01);
          tick(1);
        end
      end
    end

    tag = "R4";
    set_match();
    for (int m = 10; m <= 15; m++) begin
      wr(0, 8'hC0 | (m << 2)); tick(1); tick(0);
    end
    wr(0, 8'h44); tick(1); tick(0);

    tag = "R5";
    wr(0, 8'hA4);   // yearly, chime off
    wr(1, 8'h10);
    set_match(); cur[4] = 8'h28; tick(1);
    cur[4] = 8'h01; cur[5] = 8'h03; tick(1);
    set_match(); tick(1);

    tag = "R6";
    wr(0, 8'h84); wr(1, 8'h02);
    tick(1); peek(1); tick(1); peek(1); tick(1);
    peek(0); peek(1);
    tick(1);
    tag = "R7";
    peek(1);

    tag = "R10";
    wr(0, 8'h84);   // enabled, chime off, rpt 0
    sec_tick = 1'b1; half_tick = 1'b1; bus_sel = 2'd0; bus_wdata = 8'h84; bus_wr = 1'b1;
    cyc(); peek(0);
    wr(0, 8'hC6);   // chime, mask 1, ptr 2
    sec_tick = 1'b1; half_tick = 1'b1; bus_sel = 2'd1; bus_wdata = 8'h05; bus_wr = 1'b1;
    cyc(); peek(1);
    sec_tick = 1'b1; half_tick = 1'b1; bus_sel = 2'd2; bus_rd = 1'b1;
    cyc(); peek(0); peek(1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule